// File: doc/BRIEF.md
# Self-Correcting Johnson Decade Counter

A divide-by-ten counter whose state lives in a five-bit twisted-ring (Johnson) register. Two count inputs can advance it. The first advances the count on its rising transition, but only while the second is low. The second advances the count on its falling transition, but only while the first is high. Both inputs are brought into the system clock domain through synchronizer flops before their edges are detected. At most one step happens per system clock.

Ten active-high outputs decode the count, and each of them looks at only two adjacent register bits. An active-low carry goes low for the upper five counts, so it can feed the rising-edge count input of a following counter. A high level on the master clear input forces the count to zero at once, whatever the clock is doing. Any register pattern outside the ten legal Johnson codes is returned to count zero on the next advance. A pattern-injection port (load enable plus value) writes the register directly, so the recovery path can be exercised.

Top module: `johnson_decade`

## Requirements
- R1: Successive advances step the decoded count 0,1,2,...,9 and then wrap to 0. The register codes in that order are 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000 (bit 4 leftmost).
- R2: A rising edge on `count_up_i` while `count_dn_n_i` is low advances the count by one.
- R3: A falling edge on `count_dn_n_i` while `count_up_i` is high advances the count by one.
- R4: The count holds through each of these: a rising edge on `count_up_i` while `count_dn_n_i` is high, a falling edge on `count_dn_n_i` while `count_up_i` is low, a falling edge on `count_up_i`, and a rising edge on `count_dn_n_i`.
- R5: When both qualifying edges arrive together, the count advances exactly once.
- R6: In every legal state exactly one bit of `dec_o` is high, and that bit is bit k for count k.
- R7: `carry_n_o` is low for counts 5 to 9 and high for counts 0 to 4. In general it is the inverse of register bit 4.
- R8: While `clear_i` is high, the outputs show count 0 (`dec_o` = 1, `carry_n_o` = 1). This takes effect without waiting for a clock edge, and it overrides both the count inputs and the load port.
- R9: A clock edge with `load_en_i` high writes `load_val_i` into the register. The load takes precedence over an advance on the same edge.
- R10: An advance taken from any of the 22 illegal register patterns lands on count 0. This is well inside the limit of 11 advances.
- R11: A count-input transition changes the outputs at the third system-clock rising edge after the transition. One edge is spent in each of the two synchronizer flops and one in the state register.
- R12: On an advance between legal states, exactly one register bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| clear_i | input | 1 | Asynchronous master clear, active high |
| count_up_i | input | 1 | Count input, active on rising edge, asynchronous |
| count_dn_n_i | input | 1 | Count input, active on falling edge, asynchronous |
| load_en_i | input | 1 | Pattern-injection strobe, synchronous |
| load_val_i | input | 5 | Register pattern written when load_en_i is high |
| dec_o | output | 10 | One-hot decoded count |
| carry_n_o | output | 1 | Active-low carry, low for counts 5 to 9 |

## Verification
The assertions assume three things about the inputs:
- The count inputs only matter once they are synchronized. No property looks at their raw values.
- The load strobe is synchronous.
- The count inputs sit at their idle levels (up low, down-count high) whenever clear is released. The synchronizers reset to those levels, so a release then cannot create a false edge.

The stimulus follows these rules. It changes inputs only at falling clock edges and holds each level for at least four system clocks, so every transition passes the synchronizers cleanly. It returns both count inputs to idle before it releases clear. The bench reference model applies the same two-clock input delay and compares the decoded outputs and the carry with the model on every clock.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

    // The two count inputs carried together through the synchronizer.
    typedef struct packed {
        logic up;    // active on rising edge
        logic dn_n;  // active on falling edge
    } count_pins_t;

    // Idle levels of the count inputs; synchronizers reset to these.
    localparam logic IDLE_UP   = 1'b0;
    localparam logic IDLE_DN_N = 1'b1;

endpackage

// File: rtl/jdc_sync.sv
module jdc_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 clear_i,
    input  jdc_pkg::count_pins_t pins_i,
    output logic                 advance_o
);
    import jdc_pkg::*;

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] up;
        logic [SYNC_STAGES-1:0] dn;
        logic                   up_prev;
        logic                   dn_prev;
    } sync_t;

    sync_t q, d;
    logic  up_now, dn_now, up_rise, dn_fall;

    always_comb begin
        d = q;
        d.up[0] = pins_i.up;
        d.dn[0] = pins_i.dn_n;
        for (int i = 1; i < SYNC_STAGES; i++) begin
            d.up[i] = q.up[i-1];
            d.dn[i] = q.dn[i-1];
        end
        up_now    = q.up[LAST];
        dn_now    = q.dn[LAST];
        d.up_prev = up_now;
        d.dn_prev = dn_now;
        up_rise   = up_now & ~q.up_prev;
        dn_fall   = ~dn_now & q.dn_prev;
        // each edge is gated by the level of the other input; OR merges coincident edges
        advance_o = (up_rise & ~dn_now) | (dn_fall & up_now);
    end

    always_ff @(posedge clk_i or posedge clear_i) begin
        if (clear_i) begin
            q.up      <= {SYNC_STAGES{IDLE_UP}};
            q.dn      <= {SYNC_STAGES{IDLE_DN_N}};
            q.up_prev <= IDLE_UP;
            q.dn_prev <= IDLE_DN_N;
        end else begin
            q <= d;
        end
    end

    // R2/R3: a qualifying edge yields an advance
    p_rise_adv_r2: assert property (@(posedge clk_i) disable iff (clear_i)
        (up_now && !q.up_prev && !dn_now) |-> advance_o);
    p_fall_adv_r3: assert property (@(posedge clk_i) disable iff (clear_i)
        (!dn_now && q.dn_prev && up_now) |-> advance_o);

endmodule

// File: rtl/jdc_ring.sv
module jdc_ring #(
    parameter int STAGES = 5
) (
    input  logic              clk_i,
    input  logic              clear_i,
    input  logic              advance_i,
    input  logic              load_i,
    input  logic [STAGES-1:0] load_val_i,
    output logic [STAGES-1:0] state_o,
    output logic              legal_o
);
    localparam int MSB = STAGES - 1;
    localparam int CW  = $clog2(STAGES) + 1;

    typedef struct packed {
        logic [STAGES-1:0] ring;
    } ring_t;

    ring_t             q, d;
    logic [STAGES-1:0] stepped;
    logic [CW-1:0]     seams;

    always_comb begin
        // legal Johnson codes have at most one boundary between neighbouring bits
        seams = '0;
        for (int i = 0; i < MSB; i++) begin
            seams = seams + {{(CW-1){1'b0}}, q.ring[i] ^ q.ring[i+1]};
        end
        legal_o = (seams <= CW'(1));

        stepped[0] = ~q.ring[MSB];
        for (int i = 1; i < STAGES; i++) begin
            stepped[i] = q.ring[i-1];
        end

        d = q;
        if (load_i) begin
            d.ring = load_val_i;
        end else if (advance_i) begin
            d.ring = legal_o ? stepped : '0;
        end
        state_o = q.ring;
    end

    always_ff @(posedge clk_i or posedge clear_i) begin
        if (clear_i) q <= '0;
        else         q <= d;
    end

    p_stay_legal_r1: assert property (@(posedge clk_i) disable iff (clear_i)
        (advance_i && !load_i && legal_o) |=> legal_o);
    p_hold_r4: assert property (@(posedge clk_i) disable iff (clear_i)
        (!advance_i && !load_i) |=> $stable(q.ring));
    p_load_r9: assert property (@(posedge clk_i) disable iff (clear_i)
        load_i |=> (q.ring == $past(load_val_i)));
    p_recover_r10: assert property (@(posedge clk_i) disable iff (clear_i)
        (advance_i && !load_i && !legal_o) |=> (q.ring == '0));
    p_one_bit_r12: assert property (@(posedge clk_i) disable iff (clear_i)
        (advance_i && !load_i && legal_o) |=> ($countones(q.ring ^ $past(q.ring)) == 1));

endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
    parameter int STAGES = 5
) (
    input  logic [STAGES-1:0]   state_i,
    output logic [2*STAGES-1:0] dec_o,
    output logic                carry_n_o
);
    localparam int OUTS = 2 * STAGES;
    localparam int MSB  = STAGES - 1;

    // every output reads one pair of bits; only one bit moves per step
    for (genvar k = 0; k < OUTS; k++) begin : g_dec
        if (k == 0) begin : g_zero
            assign dec_o[k] = ~state_i[MSB] & ~state_i[0];
        end else if (k < STAGES) begin : g_fill
            assign dec_o[k] = state_i[k-1] & ~state_i[k];
        end else if (k == STAGES) begin : g_full
            assign dec_o[k] = state_i[MSB] & state_i[0];
        end else begin : g_drain
            assign dec_o[k] = ~state_i[k-STAGES-1] & state_i[k-STAGES];
        end
    end

    assign carry_n_o = ~state_i[MSB];

endmodule

// File: rtl/johnson_decade.sv
module johnson_decade #(
    parameter int STAGES      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk_i,
    input  logic                   clear_i,
    input  logic                   count_up_i,
    input  logic                   count_dn_n_i,
    input  logic                   load_en_i,
    input  logic [STAGES-1:0]      load_val_i,
    output logic [2*STAGES-1:0]    dec_o,
    output logic                   carry_n_o
);
    import jdc_pkg::*;

    localparam int OUTS = 2 * STAGES;

    count_pins_t       pins;
    logic              advance;
    logic              legal;
    logic [STAGES-1:0] state;

    assign pins.up   = count_up_i;
    assign pins.dn_n = count_dn_n_i;

    jdc_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk_i     (clk_i),
        .clear_i   (clear_i),
        .pins_i    (pins),
        .advance_o (advance)
    );

    jdc_ring #(.STAGES(STAGES)) u_ring (
        .clk_i      (clk_i),
        .clear_i    (clear_i),
        .advance_i  (advance),
        .load_i     (load_en_i),
        .load_val_i (load_val_i),
        .state_o    (state),
        .legal_o    (legal)
    );

    jdc_decode #(.STAGES(STAGES)) u_decode (
        .state_i   (state),
        .dec_o     (dec_o),
        .carry_n_o (carry_n_o)
    );

    p_onehot_r6: assert property (@(posedge clk_i) disable iff (clear_i)
        legal |-> ($countones(dec_o) == 1));
    p_carry_low_r7: assert property (@(posedge clk_i) disable iff (clear_i)
        (legal && (|dec_o[OUTS-1:STAGES])) |-> !carry_n_o);
    p_carry_high_r7: assert property (@(posedge clk_i) disable iff (clear_i)
        (legal && (|dec_o[STAGES-1:0])) |-> carry_n_o);
    p_clear_r8: assert property (@(posedge clk_i)
        clear_i |-> (dec_o == OUTS'(1) && carry_n_o));

endmodule

// File: tb/johnson_decade_tb.sv
`timescale 1ns/1ps
module johnson_decade_tb;
    localparam int N    = 5;
    localparam int OUTS = 2 * N;

    logic           clk = 1'b0;
    logic           clear, up, dn_n, ld;
    logic [N-1:0]   ld_val;
    logic [OUTS-1:0] dec;
    logic           carry_n;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    johnson_decade u_dut (
        .clk_i(clk), .clear_i(clear), .count_up_i(up), .count_dn_n_i(dn_n),
        .load_en_i(ld), .load_val_i(ld_val), .dec_o(dec), .carry_n_o(carry_n)
    );

    function automatic logic [N-1:0] jcode(int k);
        if (k <= N) return N'((1 << k) - 1);
        return N'(((1 << N) - 1) & ~((1 << (k - N)) - 1));
    endfunction

    function automatic int jindex(logic [N-1:0] p);
        for (int k = 0; k < OUTS; k++) if (jcode(k) == p) return k;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model: count value, illegal flag and delayed input history
    int           m_cnt = 0;
    bit           m_bad = 0;
    logic [N-1:0] m_raw = '0;
    bit           hu[3];
    bit           hd[3];

    always @(posedge clk or posedge clear) begin
        if (clear) begin
            m_cnt = 0; m_bad = 0;
            hu = '{0, 0, 0}; hd = '{1, 1, 1};
        end else begin
            bit adv;
            int idx;
            adv = (hu[1] && !hu[2] && !hd[1]) || (!hd[1] && hd[2] && hu[1]);
            if (ld) begin
                idx = jindex(ld_val);
                if (idx >= 0) begin m_cnt = idx; m_bad = 0; end
                else begin m_bad = 1; m_raw = ld_val; end
            end else if (adv) begin
                if (m_bad) begin m_bad = 0; m_cnt = 0; end
                else m_cnt = (m_cnt + 1) % OUTS;
            end
            hu[2] = hu[1]; hu[1] = hu[0]; hu[0] = up;
            hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = dn_n;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!clear) begin
            if (!m_bad) begin
                chk(dec == OUTS'(1 << m_cnt), "R6 decode vs model", 32'(dec), 32'(1 << m_cnt));
                chk(carry_n == (m_cnt < N), "R7 carry vs model", 32'(carry_n), 32'(m_cnt < N));
            end else begin
                chk(carry_n == !m_raw[N-1], "R7 carry on illegal code", 32'(carry_n), 32'(!m_raw[N-1]));
            end
        end
    end

    task automatic step_up();
        up = 1'b1; idle(4);
        up = 1'b0; idle(4);
    endtask

    task automatic load(input logic [N-1:0] p);
        ld = 1'b1; ld_val = p;
        @(negedge clk);
        ld = 1'b0;
    endtask

    initial begin
        clear = 1'b1; up = 1'b0; dn_n = 1'b1; ld = 1'b0; ld_val = '0;
        idle(3);
        chk(dec == 10'd1 && carry_n, "R8 reset state", 32'(dec), 32'd1);
        clear = 1'b0;
        idle(3);

        // R4: gated or wrong-direction edges leave the count alone
        up = 1'b1; idle(5);
        chk(dec == 10'd1, "R4 up rise while dn_n high", 32'(dec), 32'd1);
        up = 1'b0; idle(5);
        chk(dec == 10'd1, "R4 up fall", 32'(dec), 32'd1);
        dn_n = 1'b0; idle(5);
        chk(dec == 10'd1, "R4 dn_n fall while up low", 32'(dec), 32'd1);

        // R11 latency and R2 rising-edge advance
        up = 1'b1; idle(2);
        chk(dec == 10'd1, "R11 unchanged after two edges", 32'(dec), 32'd1);
        idle(1);
        chk(dec == 10'd2, "R11 changed on third edge", 32'(dec), 32'd2);
        chk(dec == 10'd2, "R2 rising edge advance", 32'(dec), 32'd2);
        up = 1'b0; idle(4);

        // R1 full cycle and wrap
        for (int i = 0; i < 8; i++) step_up();
        chk(dec == 10'h200 && !carry_n, "R7 count 9 carry low", 32'(dec), 32'h200);
        step_up();
        chk(dec == 10'd1 && carry_n, "R1 wrap to zero", 32'(dec), 32'd1);

        // R3 falling-edge advance with up held high
        up = 1'b1; idle(4);            // advances to 1 (dn_n low)
        dn_n = 1'b1; idle(4);
        chk(dec == 10'd2, "R4 dn_n rise", 32'(dec), 32'd2);
        dn_n = 1'b0; idle(4);
        chk(dec == 10'd4, "R3 falling edge advance", 32'(dec), 32'd4);

        // R5 coincident qualifying edges
        up = 1'b0; idle(4);
        dn_n = 1'b1; idle(4);
        chk(dec == 10'd4, "R4 idle return", 32'(dec), 32'd4);
        up = 1'b1; dn_n = 1'b0; idle(6);
        chk(dec == 10'd8, "R5 single advance", 32'(dec), 32'd8);
        up = 1'b0; idle(4);

        // R9 load a legal code (11100 = count 7)
        load(5'b11100);
        chk(dec == 10'h080 && !carry_n, "R9 load legal code", 32'(dec), 32'h080);

        // R10 every illegal code recovers to zero on one advance
        for (int p = 0; p < (1 << N); p++) begin
            if (jindex(N'(p)) < 0) begin
                load(N'(p));
                step_up();
                chk(dec == 10'd1, "R10 recovery to zero", 32'(dec), 32'd1);
            end
        end

        // R8 asynchronous clear overrides counting and load
        step_up(); step_up(); step_up();
        chk(dec == 10'd8, "R1 count 3", 32'(dec), 32'd8);
        @(negedge clk); #5;
        clear = 1'b1;
        #1;
        chk(dec == 10'd1 && carry_n, "R8 async clear", 32'(dec), 32'd1);
        up = 1'b1; ld = 1'b1; ld_val = 5'b00111; idle(5);
        chk(dec == 10'd1, "R8 override", 32'(dec), 32'd1);
        up = 1'b0; ld = 1'b0; dn_n = 1'b1; idle(2);
        clear = 1'b0; idle(5);
        chk(dec == 10'd1, "R8 after release", 32'(dec), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        chk(1'b0, "watchdog expired", 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule